// File: doc/BRIEF.md
# Programmed-I/O Strobe Timing Generator

This block runs one programmed-I/O cycle on a parallel ATA channel at a time. A host-side request names the target drive (0 or 1), the direction, which chip-select to use and a three-bit register address. The block asserts the address and chip-select and waits out an address setup phase. It then drives the read or write strobe low for an active phase and finally holds the strobes high for a recovery phase before reporting completion with a one-cycle done pulse. On reads, the data bus is captured at the closing edge of the last active cycle.

Every phase length comes from a 32-bit timing word, one for each drive, with all counts in system clocks. Register accesses use one set of fields and accesses to the 16-bit data port use another. The device can stretch the active phase by holding its ready line low. That line passes through a two-flop synchronizer and is sampled a fixed number of clocks into the active phase. The stretch is bounded by a clock limit, and when it runs out the cycle ends with a timeout flag.

Top module: `pio_strobe_gen`

## Requirements
- R1: The timing word is taken from `tmg_drv0_i` when `req_drive_i` is 0 and from `tmg_drv1_i` when it is 1, and it is latched when the request is accepted.
- R2: A register access, meaning any access other than the data port, has an address setup of bits 24:22 clocks, a strobe-low time of bits 15:12 clocks and a recovery of bits 11:8 clocks.
- R3: The data port is chip-select 0 (`req_cs1_i`=0) with address 0. It uses bits 21:19 for setup, bits 7:4 for the strobe-low time and bits 3:0 for recovery.
- R4: A timing field of zero gives a phase of exactly one clock.
- R5: A read drives only `ide_rd_n_o` low and a write drives only `ide_wr_n_o` low. The two are never low together. During a write, `ide_wdata_o` carries the request data and `ide_wdata_oe_o` is 1.
- R6: Read data is the value on `ide_rdata_i` at the clock edge that closes the last strobe-low cycle. It appears on `rdata_o` while `done_o` is high.
- R7: If the synchronized ready line is low at the sample point (active clock index `IORDY_SAMPLE_CLKS`, or the last programmed active clock if that comes first) and is still low when the programmed time ends, the strobe stays low until ready is seen high. `timeout_o` stays 0.
- R8: The stretch lasts at most `WAIT_MAX_CLKS` clocks. When the limit is reached the strobe is released and `timeout_o` is 1 together with `done_o`.
- R9: `busy_o` is 1 from the edge that accepts a request until the recovery phase ends. `done_o` pulses for one clock right after that. Requests presented while `busy_o` is 1 are ignored.
- R10: While busy, the selected chip-select (`ide_cs0_n_o` or `ide_cs1_n_o`, chosen by `req_cs1_i`) is low and `ide_addr_o` holds the request address. When idle, both chip-selects and both strobes are high.
- R11: After reset, `busy_o` and `done_o` are 0 and all chip-selects and strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmg_drv0_i | input | 32 | Timing word for drive 0 |
| tmg_drv1_i | input | 32 | Timing word for drive 1 |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_drive_i | input | 1 | Target drive |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cs1_i | input | 1 | 1 = control block select, 0 = command block select |
| req_addr_i | input | 3 | Register address |
| req_wdata_i | input | 16 | Write data |
| ide_addr_o | output | 3 | Device address lines |
| ide_cs0_n_o | output | 1 | Command block select, active low |
| ide_cs1_n_o | output | 1 | Control block select, active low |
| ide_rd_n_o | output | 1 | Read strobe, active low |
| ide_wr_n_o | output | 1 | Write strobe, active low |
| ide_wdata_o | output | 16 | Data driven to the device |
| ide_wdata_oe_o | output | 1 | Data bus drive enable |
| ide_rdata_i | input | 16 | Data from the device |
| ide_iordy_i | input | 1 | Device ready line (asynchronous) |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Captured read data |
| timeout_o | output | 1 | Wait limit reached, valid with done |

## Verification
The two drive words are filled with distinct counts in every field, so each phase length identifies which word and which field set was used. Register reads on both drives, a data-port read, a data-port write and a control-block access separate drive selection, field selection, strobe choice and chip-select choice. The modelled device changes its data on every strobe-low clock, so the captured value shows exactly which edge sampled it. An all-zero word checks the one-clock floor. The ready line is tested three ways: held high, released part way through a stretch, and held low until the limit. These separate an unchanged cycle, a bounded extension and the timeout. A request issued in the middle of a cycle must not produce a second cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int CNT_W = 4;

    // timing word field positions
    localparam int F_DHIGH_LSB  = 0;   // data-port recovery, 4 bits
    localparam int F_DLOW_LSB   = 4;   // data-port strobe low, 4 bits
    localparam int F_CHIGH_LSB  = 8;   // register recovery, 4 bits
    localparam int F_CLOW_LSB   = 12;  // register strobe low, 4 bits
    localparam int F_DSETUP_LSB = 19;  // data-port setup, 3 bits
    localparam int F_CSETUP_LSB = 22;  // register setup, 3 bits

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_WAIT,
        PH_RECOVER
    } phase_e;

    // phase lengths held as (clocks - 1)
    typedef struct packed {
        logic [CNT_W-1:0] setup_m1;
        logic [CNT_W-1:0] act_m1;
        logic [CNT_W-1:0] rec_m1;
    } phase_len_t;

endpackage

// File: rtl/pio_iordy_sync.sv
module pio_iordy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], async_i};
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import pio_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word0_i,
    input  logic [WORD_W-1:0] word1_i,
    input  logic              drive_i,
    input  logic              data_port_i,
    output phase_len_t        len_o
);
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  raw [3];   // 0 setup, 1 active, 2 recovery

    assign word = drive_i ? word1_i : word0_i;

    always_comb begin
        if (data_port_i) begin
            raw[0] = {1'b0, word[F_DSETUP_LSB +: 3]};
            raw[1] = word[F_DLOW_LSB +: CNT_W];
            raw[2] = word[F_DHIGH_LSB +: CNT_W];
        end else begin
            raw[0] = {1'b0, word[F_CSETUP_LSB +: 3]};
            raw[1] = word[F_CLOW_LSB +: CNT_W];
            raw[2] = word[F_CHIGH_LSB +: CNT_W];
        end
    end

    // a zero field still yields one clock: store max(f,1)-1
    logic [CNT_W-1:0] m1 [3];
    for (genvar g = 0; g < 3; g++) begin : g_clamp
        assign m1[g] = (raw[g] == '0) ? '0 : raw[g] - 1'b1;
    end

    assign len_o.setup_m1 = m1[0];
    assign len_o.act_m1   = m1[1];
    assign len_o.rec_m1   = m1[2];
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_pkg::*;
#(
    parameter int WAIT_MAX_CLKS     = 125,
    parameter int IORDY_SAMPLE_CLKS = 3,
    parameter int SYNC_STAGES       = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] tmg_drv0_i,
    input  logic [31:0] tmg_drv1_i,
    input  logic        req_valid_i,
    input  logic        req_drive_i,
    input  logic        req_write_i,
    input  logic        req_cs1_i,
    input  logic [2:0]  req_addr_i,
    input  logic [15:0] req_wdata_i,
    output logic [2:0]  ide_addr_o,
    output logic        ide_cs0_n_o,
    output logic        ide_cs1_n_o,
    output logic        ide_rd_n_o,
    output logic        ide_wr_n_o,
    output logic [15:0] ide_wdata_o,
    output logic        ide_wdata_oe_o,
    input  logic [15:0] ide_rdata_i,
    input  logic        ide_iordy_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        timeout_o
);
    localparam int WAIT_W = $clog2(WAIT_MAX_CLKS + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] idx;
        logic             sampled;
        logic             pend;
        logic             tmo_pend;
        logic [WAIT_W-1:0] wcnt;
        logic             write;
        logic             cs1;
        logic [2:0]       addr;
        logic [15:0]      wdata;
        logic [15:0]      rdata;
        phase_len_t       len;
        logic             done;
        logic             timeout;
    } state_t;

    state_t     s_q, s_d;
    phase_len_t sel_len;
    logic       iordy_s;
    logic       data_port;

    assign data_port = !req_cs1_i && (req_addr_i == 3'd0);

    pio_timing_sel u_sel (
        .word0_i     (tmg_drv0_i),
        .word1_i     (tmg_drv1_i),
        .drive_i     (req_drive_i),
        .data_port_i (data_port),
        .len_o       (sel_len)
    );

    pio_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ide_iordy_i),
        .sync_o  (iordy_s)
    );

    logic sample_now;
    logic pend_eff;

    always_comb begin
        s_d        = s_q;
        s_d.done    = 1'b0;
        s_d.timeout = 1'b0;
        sample_now = 1'b0;
        pend_eff   = s_q.pend;

        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid_i) begin
                    s_d.ph       = PH_SETUP;
                    s_d.write    = req_write_i;
                    s_d.cs1      = req_cs1_i;
                    s_d.addr     = req_addr_i;
                    s_d.wdata    = req_wdata_i;
                    s_d.len      = sel_len;
                    s_d.cnt      = sel_len.setup_m1;
                    s_d.tmo_pend = 1'b0;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph      = PH_ACTIVE;
                    s_d.cnt     = s_q.len.act_m1;
                    s_d.idx     = '0;
                    s_d.sampled = 1'b0;
                    s_d.pend    = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_ACTIVE: begin
                sample_now = !s_q.sampled &&
                             ((int'(s_q.idx) == IORDY_SAMPLE_CLKS) || (s_q.cnt == '0));
                if (sample_now) begin
                    s_d.sampled = 1'b1;
                    s_d.pend    = !iordy_s;
                    pend_eff    = !iordy_s;
                end
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.cnt == '0) begin
                    if (pend_eff && !iordy_s) begin
                        s_d.ph   = PH_WAIT;
                        s_d.wcnt = '0;
                    end else begin
                        s_d.ph    = PH_RECOVER;
                        s_d.cnt   = s_q.len.rec_m1;
                        s_d.rdata = ide_rdata_i;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_WAIT: begin
                if (iordy_s) begin
                    s_d.ph    = PH_RECOVER;
                    s_d.cnt   = s_q.len.rec_m1;
                    s_d.rdata = ide_rdata_i;
                end else if (s_q.wcnt == WAIT_W'(WAIT_MAX_CLKS - 1)) begin
                    s_d.ph       = PH_RECOVER;
                    s_d.cnt      = s_q.len.rec_m1;
                    s_d.rdata    = ide_rdata_i;
                    s_d.tmo_pend = 1'b1;
                end else begin
                    s_d.wcnt = s_q.wcnt + 1'b1;
                end
            end
            PH_RECOVER: begin
                if (s_q.cnt == '0) begin
                    s_d.ph      = PH_IDLE;
                    s_d.done    = 1'b1;
                    s_d.timeout = s_q.tmo_pend;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    logic strobe_on;
    assign strobe_on      = (s_q.ph == PH_ACTIVE) || (s_q.ph == PH_WAIT);
    assign busy_o         = (s_q.ph != PH_IDLE);
    assign ide_addr_o     = busy_o ? s_q.addr : 3'd0;
    assign ide_cs0_n_o    = !(busy_o && !s_q.cs1);
    assign ide_cs1_n_o    = !(busy_o && s_q.cs1);
    assign ide_rd_n_o     = !(strobe_on && !s_q.write);
    assign ide_wr_n_o     = !(strobe_on && s_q.write);
    assign ide_wdata_o    = s_q.wdata;
    assign ide_wdata_oe_o = busy_o && s_q.write;
    assign done_o         = s_q.done;
    assign timeout_o      = s_q.timeout;
    assign rdata_o        = s_q.rdata;
endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk #(
    parameter int WAIT_MAX_CLKS = 125
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       timeout,
    input logic       rd_n,
    input logic       wr_n,
    input logic       cs0_n,
    input logic       cs1_n,
    input logic [2:0] addr
);
    localparam int LOW_LIM = 16 + WAIT_MAX_CLKS;
    localparam int LW      = $clog2(LOW_LIM + 2) + 1;

    logic [LW-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_run <= '0;
        else if (!rd_n || !wr_n) low_run <= low_run + 1'b1;
        else                     low_run <= '0;
    end

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && cs0_n && cs1_n));

    assert_strobe_has_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> ($countones({!cs0_n, !cs1_n}) == 1));

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr));

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_timeout_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);

    assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(low_run) <= LOW_LIM);
endmodule

bind pio_strobe_gen pio_strobe_chk #(.WAIT_MAX_CLKS(WAIT_MAX_CLKS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_o),
    .done    (done_o),
    .timeout (timeout_o),
    .rd_n    (ide_rd_n_o),
    .wr_n    (ide_wr_n_o),
    .cs0_n   (ide_cs0_n_o),
    .cs1_n   (ide_cs1_n_o),
    .addr    (ide_addr_o)
);

// File: tb/tb_pio_strobe_gen.sv
module tb_pio_strobe_gen;
    localparam int WMAX = 20;
    // W0: csetup2 dsetup3 clow4 chigh3 dlow5 dhigh2 ; W1: csetup1 dsetup2 clow7 chigh5 dlow3 dhigh6
    localparam logic [31:0] W0 = 32'h0098_4352;
    localparam logic [31:0] W1 = 32'h0050_7536;

    logic clk = 0, rst_n = 0;
    logic [31:0] tmg0 = W0, tmg1 = W1;
    logic req_valid = 0, req_drive = 0, req_write = 0, req_cs1 = 0;
    logic [2:0]  req_addr = 0;
    logic [15:0] req_wdata = 0, ide_rdata = 16'hDEAD;
    logic iordy = 1;
    logic [2:0]  ide_addr;
    logic cs0_n, cs1_n, rd_n, wr_n, wdata_oe, busy, done, tmo;
    logic [15:0] ide_wdata, rdata;

    always #5 clk = ~clk;

    pio_strobe_gen #(.WAIT_MAX_CLKS(WMAX), .IORDY_SAMPLE_CLKS(3), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .tmg_drv0_i(tmg0), .tmg_drv1_i(tmg1),
        .req_valid_i(req_valid), .req_drive_i(req_drive), .req_write_i(req_write),
        .req_cs1_i(req_cs1), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .ide_addr_o(ide_addr), .ide_cs0_n_o(cs0_n), .ide_cs1_n_o(cs1_n),
        .ide_rd_n_o(rd_n), .ide_wr_n_o(wr_n), .ide_wdata_o(ide_wdata),
        .ide_wdata_oe_o(wdata_oe), .ide_rdata_i(ide_rdata), .ide_iordy_i(iordy),
        .busy_o(busy), .done_o(done), .rdata_o(rdata), .timeout_o(tmo));

    int n_chk = 0, n_bad = 0;

    // monitor: counts phase lengths at negedge, models device read data
    int m_set, m_act, m_rec, ntx = 0;
    logic m_seen, m_rd, m_wr, m_cs0, m_cs1, m_oe;
    logic [2:0] m_addr;
    logic [15:0] m_wd;
    int r_set, r_act, r_rec;
    logic r_rd, r_wr, r_cs0, r_cs1, r_oe, r_tmo;
    logic [2:0] r_addr;
    logic [15:0] r_wd, r_rdata;

    task automatic mon_clear();
        m_set = 0; m_act = 0; m_rec = 0; m_seen = 0; m_rd = 0; m_wr = 0;
        m_cs0 = 0; m_cs1 = 0; m_oe = 0; m_addr = 0; m_wd = 0;
    endtask

    initial mon_clear();

    always @(negedge clk) begin
        if (rst_n) begin
            if (!rd_n || !wr_n) begin
                m_act++; m_seen = 1;
                m_rd |= !rd_n; m_wr |= !wr_n;
                m_cs0 = !cs0_n; m_cs1 = !cs1_n; m_addr = ide_addr;
                m_wd = ide_wdata; m_oe = wdata_oe;
                ide_rdata = 16'hC000 | 16'(m_act);
            end else begin
                ide_rdata = 16'hDEAD;
                if (busy) begin
                    if (m_seen) m_rec++; else m_set++;
                end
            end
            if (done) begin
                r_set = m_set; r_act = m_act; r_rec = m_rec; r_rd = m_rd; r_wr = m_wr;
                r_cs0 = m_cs0; r_cs1 = m_cs1; r_addr = m_addr; r_wd = m_wd; r_oe = m_oe;
                r_rdata = rdata; r_tmo = tmo;
                mon_clear();
                ntx++;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic start_req(bit drv, bit wr, bit cs1, logic [2:0] a, logic [15:0] wd);
        @(negedge clk);
        while (busy || done) @(negedge clk);
        req_drive = drv; req_write = wr; req_cs1 = cs1; req_addr = a; req_wdata = wd;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_done(int start);
        while (ntx == start) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(bit drv, bit wr, bit cs1, logic [2:0] a, logic [15:0] wd);
        int s = ntx;
        start_req(drv, wr, cs1, a, wd);
        wait_done(s);
    endtask

    task automatic t_reset();
        chk("R11", "busy", busy, 0);
        chk("R11", "done", done, 0);
        chk("R11", "strobes/cs", {rd_n, wr_n, cs0_n, cs1_n}, 4'hF);
    endtask

    task automatic t_reg_read_d0();
        tmg0 = W0; run(0, 0, 0, 3'd7, 0);
        chk("R2", "setup", r_set, 2); chk("R2", "active", r_act, 4); chk("R2", "recovery", r_rec, 3);
        chk("R5", "rd/wr", {r_rd, r_wr}, 2'b10);
        chk("R10", "cs0/cs1", {r_cs0, r_cs1}, 2'b10); chk("R10", "addr", r_addr, 7);
        chk("R6", "rdata", r_rdata, 16'hC004); chk("R7", "timeout", r_tmo, 0);
    endtask

    task automatic t_reg_read_d1();
        run(1, 0, 0, 3'd2, 0);
        chk("R1", "setup", r_set, 1); chk("R1", "active", r_act, 7); chk("R1", "recovery", r_rec, 5);
        chk("R6", "rdata", r_rdata, 16'hC007);
    endtask

    task automatic t_data_read_d0();
        run(0, 0, 0, 3'd0, 0);
        chk("R3", "setup", r_set, 3); chk("R3", "active", r_act, 5); chk("R3", "recovery", r_rec, 2);
        chk("R6", "rdata", r_rdata, 16'hC005);
    endtask

    task automatic t_data_write_d1();
        run(1, 1, 0, 3'd0, 16'h5A3C);
        chk("R3", "setup", r_set, 2); chk("R3", "active", r_act, 3); chk("R3", "recovery", r_rec, 6);
        chk("R5", "rd/wr", {r_rd, r_wr}, 2'b01);
        chk("R5", "wdata", r_wd, 16'h5A3C); chk("R5", "oe", r_oe, 1);
    endtask

    task automatic t_ctrl_cs1();
        run(0, 0, 1, 3'd6, 0);
        chk("R10", "cs0/cs1", {r_cs0, r_cs1}, 2'b01); chk("R10", "addr", r_addr, 6);
        chk("R2", "active on cs1 addr", r_act, 4); chk("R2", "setup on cs1", r_set, 2);
    endtask

    task automatic t_zero_word();
        tmg0 = 32'h0; run(0, 0, 0, 3'd1, 0);
        chk("R4", "setup", r_set, 1); chk("R4", "active", r_act, 1); chk("R4", "recovery", r_rec, 1);
        chk("R6", "rdata", r_rdata, 16'hC001);
        tmg0 = W0;
    endtask

    task automatic t_wait_release();
        int s = ntx;
        iordy = 0;
        start_req(0, 0, 0, 3'd5, 0);
        while (m_act < 8) @(negedge clk);
        iordy = 1;
        wait_done(s);
        chk("R7", "stretched", int'(r_act > 4 && r_act < 4 + WMAX), 1);
        chk("R7", "timeout", r_tmo, 0);
        chk("R6", "rdata after wait", r_rdata, 16'hC000 | 16'(r_act));
        chk("R7", "recovery", r_rec, 3);
    endtask

    task automatic t_timeout();
        iordy = 0;
        run(0, 0, 0, 3'd4, 0);
        chk("R8", "active incl wait", r_act, 4 + WMAX);
        chk("R8", "timeout", r_tmo, 1);
        iordy = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        int s = ntx;
        start_req(0, 0, 0, 3'd3, 0);
        @(negedge clk);
        chk("R9", "busy mid-cycle", busy, 1);
        req_addr = 3'd1; req_write = 1; req_valid = 1;
        @(negedge clk); req_valid = 0;
        wait_done(s);
        repeat (25) @(negedge clk);
        chk("R9", "cycles completed", ntx - s, 1);
        chk("R9", "busy after done", busy, 0);
        chk("R9", "addr of served req", r_addr, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (3) @(negedge clk);
        t_reg_read_d0();
        t_reg_read_d1();
        t_data_read_d0();
        t_data_write_d1();
        t_ctrl_cs1();
        t_zero_word();
        t_wait_release();
        t_timeout();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule